// File: doc/BRIEF.md
# Mode-Selectable Four-Input Logic Gate

This block combines up to four boolean inputs into one boolean result. A mode code picks the combining function: all-true (AND), any-true (OR), exactly-one-true, or odd parity. A per-input enable mask decides which inputs take part, so the same block serves as a 2-, 3- or 4-input gate. Two rules apply to an input that is switched off. It counts as true for the all-true function, so it cannot pull that result low. It counts as false for the other three functions, so it adds nothing to the count.

The result is registered and is updated only in a cycle where the single-cycle process strobe is high. This models one step of a cyclic scan through a function table. Mode code 0 marks the end of the table. On a strobe with that code the result is held and a wrap flag is raised for one cycle. A mode code that the block does not recognise leaves the result untouched.

Top module: `quad_logic_gate`

## Requirements
- R1: With mode_i = 1 (all-true), a strobe loads result_o = 1 exactly when every enabled input is 1.
- R2: With mode_i = 2 (any-true), a strobe loads result_o = 1 exactly when at least one enabled input is 1.
- R3: With mode_i = 3 (exactly-one), a strobe loads result_o = 1 exactly when the number of enabled inputs at 1 equals one.
- R4: With mode_i = 4 (odd parity), a strobe loads result_o = 1 when the number of enabled inputs at 1 is odd, and 0 when it is even.
- R5: Bit i of en_mask_i = 1 enables in_i[i]. A disabled input counts as 1 for mode 1 and as 0 for modes 2, 3 and 4. With en_mask_i = 0, mode 1 gives 1 and modes 2, 3 and 4 give 0.
- R6: result_o changes only on the rising edge where strobe_i was sampled high. On every other edge it holds its value.
- R7: A strobe with mode_i = 0 (end of table) leaves result_o unchanged and drives wrap_o high for the following cycle only. wrap_o is 1 only in the cycle after such a strobe.
- R8: A strobe with mode_i in 5..7 leaves result_o unchanged and keeps wrap_o at 0.
- R9: While rst_ni is low, result_o and wrap_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Process strobe, one cycle per scan step |
| mode_i | input | 3 | Function code: 0 end, 1 all, 2 any, 3 exactly-one, 4 odd parity |
| en_mask_i | input | 4 | Per-input enable, 1 = input takes part |
| in_i | input | 4 | Boolean inputs |
| result_o | output | 1 | Registered function result |
| wrap_o | output | 1 | One-cycle end-of-table flag |

## Verification
The assertions check three things on every cycle. The result holds when no strobe is present. End-of-table and unknown codes neither change the result nor raise the wrap flag wrongly. The four function terms stay mutually consistent: exactly-one implies both odd parity and any-true. For the parity mode, the assertions also check that the registered value follows the computed term. Whether each function gives the right value for every mask and input pattern can only be shown by the bench. It steps exhaustively through all modes, all masks and all input patterns against its reference model, including the all-disabled corner.

// File: rtl/qlg_pkg.sv
package qlg_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_END = 3'd0,
    MODE_ALL = 3'd1,
    MODE_ANY = 3'd2,
    MODE_ONE = 3'd3,
    MODE_ODD = 3'd4
  } mode_e;

  typedef struct packed {
    logic all_f;
    logic any_f;
    logic one_f;
    logic odd_f;
  } fn_t;
endpackage

// File: rtl/qlg_mask.sv
module qlg_mask #(
  parameter int unsigned N_IN = 4
) (
  input  logic [N_IN-1:0] in_i,
  input  logic [N_IN-1:0] en_i,
  output logic [N_IN-1:0] and_term_o,
  output logic [N_IN-1:0] cnt_term_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    // disabled lane: neutral 1 for AND, neutral 0 for counting functions
    assign and_term_o[i] = in_i[i] | ~en_i[i];
    assign cnt_term_o[i] = in_i[i] & en_i[i];
  end
endmodule

// File: rtl/qlg_eval.sv
module qlg_eval
  import qlg_pkg::*;
#(
  parameter int unsigned N_IN = 4
) (
  input  logic [N_IN-1:0] and_term_i,
  input  logic [N_IN-1:0] cnt_term_i,
  output fn_t             fn_o
);
  localparam int unsigned CNT_W = $clog2(N_IN + 1);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_IN; i++) ones = ones + CNT_W'(cnt_term_i[i]);
  end

  assign fn_o.all_f = &and_term_i;
  assign fn_o.any_f = |cnt_term_i;
  assign fn_o.one_f = (ones == CNT_W'(1));
  assign fn_o.odd_f = ^cnt_term_i;
endmodule

// File: rtl/qlg_out_stage.sv
module qlg_out_stage
  import qlg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [MODE_W-1:0] mode_i,
  input  fn_t               fn_i,
  output logic              result_o,
  output logic              wrap_o
);
  logic sel_val;
  logic load;
  logic is_end;

  always_comb begin
    sel_val = 1'b0;
    load    = 1'b0;
    is_end  = 1'b0;
    unique case (mode_e'(mode_i))
      MODE_END: is_end = 1'b1;
      MODE_ALL: begin sel_val = fn_i.all_f; load = 1'b1; end
      MODE_ANY: begin sel_val = fn_i.any_f; load = 1'b1; end
      MODE_ONE: begin sel_val = fn_i.one_f; load = 1'b1; end
      MODE_ODD: begin sel_val = fn_i.odd_f; load = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= 1'b0;
      wrap_o   <= 1'b0;
    end else begin
      wrap_o <= strobe_i & is_end;
      if (strobe_i && load) result_o <= sel_val;
    end
  end

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(result_o));

  assert_end_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == 3'd0) |=> ($stable(result_o) && wrap_o));

  assert_wrap_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> ($past(strobe_i) && $past(mode_i) == 3'd0));

  assert_bad_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i > 3'd4) |=> ($stable(result_o) && !wrap_o));

  assert_odd_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == 3'd4) |=> (result_o == $past(fn_i.odd_f)));
endmodule

// File: rtl/quad_logic_gate.sv
module quad_logic_gate
  import qlg_pkg::*;
#(
  parameter int unsigned N_IN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [2:0]        mode_i,
  input  logic [N_IN-1:0]   en_mask_i,
  input  logic [N_IN-1:0]   in_i,
  output logic              result_o,
  output logic              wrap_o
);
  logic [N_IN-1:0] and_term;
  logic [N_IN-1:0] cnt_term;
  fn_t             fn;

  qlg_mask #(.N_IN(N_IN)) u_mask (
    .in_i       (in_i),
    .en_i       (en_mask_i),
    .and_term_o (and_term),
    .cnt_term_o (cnt_term)
  );

  qlg_eval #(.N_IN(N_IN)) u_eval (
    .and_term_i (and_term),
    .cnt_term_i (cnt_term),
    .fn_o       (fn)
  );

  qlg_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .mode_i   (mode_i),
    .fn_i     (fn),
    .result_o (result_o),
    .wrap_o   (wrap_o)
  );

  assert_one_implies_odd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn.one_f |-> (fn.odd_f && fn.any_f));

  assert_all_implies_any_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn.all_f && |en_mask_i) |-> fn.any_f);

  assert_empty_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mask_i == '0) |-> (fn.all_f && !fn.any_f && !fn.one_f && !fn.odd_f));
endmodule

// File: tb/quad_logic_gate_test.sv
module quad_logic_gate_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [3:0] en_mask_i = 4'h0;
  logic [3:0] in_i = 4'h0;
  logic       result_o;
  logic       wrap_o;

  int checks = 0;
  int errors = 0;
  bit exp_res = 1'b0;
  bit exp_wrap = 1'b0;

  always #10 clk_i = ~clk_i;

  quad_logic_gate uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .mode_i(mode_i),
    .en_mask_i(en_mask_i), .in_i(in_i), .result_o(result_o), .wrap_o(wrap_o)
  );

  function automatic bit ref_fn(int mode, bit [3:0] msk, bit [3:0] v);
    int cnt = 0;
    bit all = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (msk[i]) begin
        if (v[i]) cnt++;
        else all = 1'b0;
      end
    end
    case (mode)
      1: return all;
      2: return cnt > 0;
      3: return cnt == 1;
      4: return (cnt % 2) == 1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(bit stb, int mode, bit [3:0] msk, bit [3:0] v, string tag);
    strobe_i  = stb;
    mode_i    = 3'(mode);
    en_mask_i = msk;
    in_i      = v;
    @(posedge clk_i);
    exp_wrap = stb && (mode == 0);
    if (stb && mode >= 1 && mode <= 4) exp_res = ref_fn(mode, msk, v);
    @(negedge clk_i);
    check(result_o, exp_res, {tag, " result"});
    check(wrap_o, exp_wrap, {tag, " wrap"});
  endtask

  function automatic string mode_tag(int mode, bit [3:0] msk);
    if (msk != 4'hF) return "R5";
    case (mode)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    check(result_o, 1'b0, "R9 reset result");
    check(wrap_o, 1'b0, "R9 reset wrap");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // exhaustive function sweep with idle cycles that must not disturb result
    for (int m = 1; m <= 4; m++) begin
      for (int k = 0; k < 16; k++) begin
        for (int v = 0; v < 16; v++) begin
          step(1'b1, m, 4'(k), 4'(v), mode_tag(m, 4'(k)));
          step(1'b0, m, 4'(k), 4'(~v), "R6 idle");
        end
      end
    end

    // empty mask corners
    step(1'b1, 1, 4'h0, 4'h0, "R5 empty all");
    check(result_o, 1'b1, "R5 empty all=1");
    step(1'b1, 2, 4'h0, 4'hF, "R5 empty any");
    check(result_o, 1'b0, "R5 empty any=0");

    // end-of-table: hold and one-cycle wrap
    step(1'b1, 1, 4'hF, 4'hF, "R1 set");
    step(1'b1, 0, 4'hF, 4'h0, "R7 end");
    check(wrap_o, 1'b1, "R7 wrap high");
    check(result_o, 1'b1, "R7 hold");
    step(1'b0, 0, 4'hF, 4'h0, "R7 wrap drop");
    check(wrap_o, 1'b0, "R7 wrap one cycle");

    // unknown codes
    for (int m = 5; m <= 7; m++) begin
      step(1'b1, m, 4'hF, 4'h0, "R8 bad code");
      check(result_o, 1'b1, "R8 hold");
    end
    step(1'b1, 2, 4'hF, 4'h0, "R2 clear");
    for (int m = 5; m <= 7; m++) step(1'b1, m, 4'hF, 4'hF, "R8 bad code low");

    // strobe-less mode 0 raises nothing
    step(1'b0, 0, 4'h0, 4'h0, "R7 no strobe");

    // reset mid-run
    step(1'b1, 1, 4'h3, 4'h3, "R1 pre-reset");
    rst_ni = 1'b0;
    #1;
    check(result_o, 1'b0, "R9 async result");
    check(wrap_o, 1'b0, "R9 async wrap");
    exp_res = 1'b0;
    exp_wrap = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 1, 4'hF, 4'hF, "R9 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule